// File: doc/BRIEF.md
# Subchannel Function Control Sequencer

This block is the control state machine for a single I/O subchannel. A processor-side command port issues start, halt, clear, resume, cancel and status-accept operations. Each command gets a condition code one cycle later. An accepted start latches a request block: an interruption parameter, a logical path mask and a channel-program address. The block keeps the function-control and activity-control bits and the status-pending flag.

In every cycle that carries no command, the block serves one pending function, chosen by fixed priority. A start, or a resume of a suspended program, produces a start-program strobe together with the program address. An external executor later reports done or suspended, along with device and channel status. Every function that completes raises a one-cycle interrupt request. That request carries the interruption parameter and a completion condition code. Fetching and executing channel commands is not part of this block.

Top module: `subch_fc_seq`

## Requirements
- R1: Command opcodes are start=1, halt=2, clear=3, resume=4, cancel=5, accept=6; opcodes 0 and 7 return cc 3. The cc appears on `resp_cc` with `resp_valid` in the cycle after the command. A rejected command (nonzero cc) changes no state. Start, halt, resume and cancel return cc 1 while status is pending. Otherwise cc 2 is returned in these cases: a start while any function bit is set; a halt while clear is set; a resume unless only start is set and the subchannel is suspended with no resume pending; a cancel unless start is set together with start-pending or suspended. Accept returns cc 1 when no status is pending.
- R2: `fn_ctl` bits are start=0, halt=1, clear=2. `act_ctl` bits are active=0, suspended=1, start-pending=2, resume-pending=3, halt-pending=4, clear-pending=5. An accepted start sets `fn_ctl`=001 and start-pending, loads the program address, and zeroes device and channel status.
- R3: Path 0x80 is the only path. If the latched mask has that bit, the start is served in the first cycle with no command. That serving copies the interruption parameter to `path_intparm`, pulses `prog_start` with `prog_addr` equal to the latched address, sets `last_cmd_valid`, and leaves only active set.
- R4: If the latched mask lacks the path bit, the start ends with an interrupt of completion cc 3 that carries the request's parameter. Status becomes pending and `prog_start` does not pulse.
- R5: Pending functions are served clear first, then halt, then start. A served halt or clear zeroes the program address, drops `last_cmd_valid` and all activity bits, sets status pending and raises an interrupt with completion cc 0.
- R6: Clear is always accepted, even while status is pending. It drops status pending, sets `fn_ctl`=100 and leaves only clear-pending in `act_ctl`.
- R7: `prog_done` while active drops active, sets status pending, captures `prog_dstat`/`prog_cstat` and raises an interrupt with completion cc 0 carrying `path_intparm`.
- R8: `prog_suspend` while active sets suspended and raises no interrupt. A resume restarts at the same program address. It reads no new request block, so neither a rejected start's parameter nor its address is used.
- R9: An accepted cancel clears the start, start-pending and suspended bits, zeroes the program address and `last_cmd_valid`, and zeroes device and channel status, with no interrupt.
- R10: An accepted accept drops status pending and clears all function and activity bits.
- R11: Reset clears all function, activity and status state, the program address, `last_cmd_valid` and all strobes, even mid-program.
- R12: `irq` is a pulse lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_intparm | input | IP_W | Request-block interruption parameter |
| cmd_lpm | input | LPM_W | Request-block logical path mask |
| cmd_cpa | input | CPA_W | Request-block channel-program address |
| resp_valid | output | 1 | Condition code valid |
| resp_cc | output | 2 | Condition code of the previous command |
| fn_ctl | output | 3 | Function-control bits |
| act_ctl | output | 6 | Activity-control bits |
| stat_pend | output | 1 | Status pending |
| dev_stat | output | STAT_W | Device status |
| chn_stat | output | STAT_W | Channel status |
| last_cmd_valid | output | 1 | Last command record valid |
| path_intparm | output | IP_W | Path-management interruption parameter |
| prog_start | output | 1 | Start-program strobe |
| prog_addr | output | CPA_W | Stored channel-program address |
| prog_done | input | 1 | Program finished |
| prog_suspend | input | 1 | Program suspended |
| prog_dstat | input | STAT_W | Device status from executor |
| prog_cstat | input | STAT_W | Channel status from executor |
| irq | output | 1 | Interrupt request pulse |
| irq_cc | output | 2 | Completion condition code |
| irq_parm | output | IP_W | Interruption parameter of the interrupt |

## Verification
The bench issues a halt in the cycle right after a start, so both are pending at once. A design that ignored the priority would pulse `prog_start` instead of raising the halt interrupt. A start whose mask misses the single path must give a cc-3 interrupt with no strobe; a design that skipped the mask test would launch a program. On the resume path a rejected start carries a new parameter and address. A design that refetched the request block would restart at the wrong address or report the wrong parameter. Cancel after a suspension must wipe the captured device status and the address, and a reset in the middle of a program must drop `last_cmd_valid`.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_START  = 3'd1,
      OP_HALT   = 3'd2,
      OP_CLEAR  = 3'd3,
      OP_RESUME = 3'd4,
      OP_CANCEL = 3'd5,
      OP_ACCEPT = 3'd6,
      OP_RSVD   = 3'd7
   } sfc_op_e;

   typedef enum logic [1:0] {
      CC_OK     = 2'd0,
      CC_STATUS = 2'd1,
      CC_BUSY   = 2'd2,
      CC_NOPATH = 2'd3
   } sfc_cc_e;

   localparam int FN_W   = 3;
   localparam int FN_ST  = 0;
   localparam int FN_HT  = 1;
   localparam int FN_CL  = 2;

   localparam int ACT_W    = 6;
   localparam int ACT_RUN  = 0;
   localparam int ACT_SUSP = 1;
   localparam int ACT_STP  = 2;
   localparam int ACT_RSP  = 3;
   localparam int ACT_HTP  = 4;
   localparam int ACT_CLP  = 5;
endpackage

// File: rtl/sfc_cmd_check.sv
module sfc_cmd_check
   import sfc_pkg::*;
(
   input  logic [2:0]       op,
   input  logic [FN_W-1:0]  fn_q,
   input  logic [ACT_W-1:0] act_q,
   input  logic             stat_q,
   output sfc_cc_e          cc,
   output logic             ok
);
   always_comb begin
      cc = CC_OK;
      unique case (sfc_op_e'(op))
         OP_START:  if (stat_q) cc = CC_STATUS;
                    else if (fn_q != '0) cc = CC_BUSY;
         OP_HALT:   if (stat_q) cc = CC_STATUS;
                    else if (fn_q[FN_CL]) cc = CC_BUSY;
         OP_CLEAR:  cc = CC_OK;
         OP_RESUME: if (stat_q) cc = CC_STATUS;
                    else if (!(fn_q == 3'b001 && act_q[ACT_SUSP] && !act_q[ACT_RSP]))
                       cc = CC_BUSY;
         OP_CANCEL: if (stat_q) cc = CC_STATUS;
                    else if (!(fn_q[FN_ST] && (act_q[ACT_STP] || act_q[ACT_SUSP])))
                       cc = CC_BUSY;
         OP_ACCEPT: if (!stat_q) cc = CC_STATUS;
         default:   cc = CC_NOPATH;
      endcase
      ok = (cc == CC_OK);
   end
endmodule

// File: rtl/sfc_prio_pick.sv
module sfc_prio_pick #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   if (N < 2) begin : g_bad_n
      $error("sfc_prio_pick: N must be at least 2");
   end

   logic [N:0] above;
   assign above[N] = 1'b0;

   for (genvar i = N - 1; i >= 0; i--) begin : g_lvl
      assign above[i] = above[i+1] | req[i];
      assign grant[i] = req[i] & ~above[i+1];
   end

   // R5
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R5
   grant_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req[N-1] |-> grant[N-1]);
endmodule

// File: rtl/sfc_orb_latch.sv
module sfc_orb_latch #(
   parameter int          IP_W      = 32,
   parameter int          LPM_W     = 8,
   parameter logic [LPM_W-1:0] PATH_MASK = 8'h80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IP_W-1:0]  ip_in,
   input  logic [LPM_W-1:0] lpm_in,
   output logic [IP_W-1:0]  ip_q,
   output logic             path_ok
);
   if (PATH_MASK == '0) begin : g_bad_path
      $error("sfc_orb_latch: PATH_MASK selects no path");
   end

   logic [LPM_W-1:0] lpm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip_q  <= '0;
         lpm_q <= '0;
      end else if (load) begin
         ip_q  <= ip_in;
         lpm_q <= lpm_in;
      end
   end

   assign path_ok = |(lpm_q & PATH_MASK);
endmodule

// File: rtl/subch_fc_seq.sv
module subch_fc_seq
   import sfc_pkg::*;
#(
   parameter int IP_W   = 32,
   parameter int LPM_W  = 8,
   parameter int CPA_W  = 32,
   parameter int STAT_W = 8,
   parameter logic [LPM_W-1:0] PATH_MASK = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [IP_W-1:0]   cmd_intparm,
   input  logic [LPM_W-1:0]  cmd_lpm,
   input  logic [CPA_W-1:0]  cmd_cpa,
   output logic              resp_valid,
   output logic [1:0]        resp_cc,
   output logic [2:0]        fn_ctl,
   output logic [5:0]        act_ctl,
   output logic              stat_pend,
   output logic [STAT_W-1:0] dev_stat,
   output logic [STAT_W-1:0] chn_stat,
   output logic              last_cmd_valid,
   output logic [IP_W-1:0]   path_intparm,
   output logic              prog_start,
   output logic [CPA_W-1:0]  prog_addr,
   input  logic              prog_done,
   input  logic              prog_suspend,
   input  logic [STAT_W-1:0] prog_dstat,
   input  logic [STAT_W-1:0] prog_cstat,
   output logic              irq,
   output logic [1:0]        irq_cc,
   output logic [IP_W-1:0]   irq_parm
);
   localparam int NREQ  = 3;
   localparam int Q_ST  = 0;
   localparam int Q_HT  = 1;
   localparam int Q_CL  = 2;

   if (IP_W < 1 || CPA_W < 1 || STAT_W < 1) begin : g_bad_w
      $error("subch_fc_seq: widths must be positive");
   end
   if (LPM_W < 1) begin : g_bad_lpm
      $error("subch_fc_seq: LPM_W must be positive");
   end

   logic [FN_W-1:0]   fn_q;
   logic [ACT_W-1:0]  act_q;
   logic              stat_q;
   logic [CPA_W-1:0]  cpa_q;
   logic              lcv_q;
   logic [IP_W-1:0]   pip_q;
   logic [STAT_W-1:0] dst_q, cst_q;
   logic              irq_q, start_q, rv_q;
   logic [1:0]        icc_q, rcc_q;
   logic [IP_W-1:0]   iparm_q;

   sfc_cc_e           chk_cc;
   logic              chk_ok;
   logic              acc;
   logic [NREQ-1:0]   req, grant;
   logic              disp_en;
   logic [IP_W-1:0]   orb_ip;
   logic              orb_path_ok;

   sfc_cmd_check u_chk (
      .op     (cmd_op),
      .fn_q   (fn_q),
      .act_q  (act_q),
      .stat_q (stat_q),
      .cc     (chk_cc),
      .ok     (chk_ok)
   );

   assign acc = cmd_valid & chk_ok;

   sfc_orb_latch #(
      .IP_W      (IP_W),
      .LPM_W     (LPM_W),
      .PATH_MASK (PATH_MASK)
   ) u_orb (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (acc && (sfc_op_e'(cmd_op) == OP_START)),
      .ip_in   (cmd_intparm),
      .lpm_in  (cmd_lpm),
      .ip_q    (orb_ip),
      .path_ok (orb_path_ok)
   );

   assign req[Q_CL] = act_q[ACT_CLP];
   assign req[Q_HT] = act_q[ACT_HTP];
   assign req[Q_ST] = (act_q[ACT_STP] && !act_q[ACT_SUSP]) ||
                      (act_q[ACT_RSP] && act_q[ACT_SUSP]);

   sfc_prio_pick #(.N(NREQ)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .grant (grant)
   );

   assign disp_en = !cmd_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_q    <= '0;
         act_q   <= '0;
         stat_q  <= 1'b0;
         cpa_q   <= '0;
         lcv_q   <= 1'b0;
         pip_q   <= '0;
         dst_q   <= '0;
         cst_q   <= '0;
         irq_q   <= 1'b0;
         icc_q   <= CC_OK;
         iparm_q <= '0;
         start_q <= 1'b0;
         rv_q    <= 1'b0;
         rcc_q   <= CC_OK;
      end else begin
         irq_q   <= 1'b0;
         start_q <= 1'b0;
         rv_q    <= cmd_valid;
         rcc_q   <= cmd_valid ? chk_cc : CC_OK;

         // executor result
         if (act_q[ACT_RUN] && prog_done) begin
            act_q[ACT_RUN] <= 1'b0;
            stat_q  <= 1'b1;
            dst_q   <= prog_dstat;
            cst_q   <= prog_cstat;
            irq_q   <= 1'b1;
            icc_q   <= CC_OK;
            iparm_q <= pip_q;
         end else if (act_q[ACT_RUN] && prog_suspend) begin
            act_q[ACT_RUN]  <= 1'b0;
            act_q[ACT_SUSP] <= 1'b1;
            dst_q <= prog_dstat;
            cst_q <= prog_cstat;
         end

         // function dispatch
         if (disp_en) begin
            if (grant[Q_CL] || grant[Q_HT]) begin
               cpa_q   <= '0;
               lcv_q   <= 1'b0;
               act_q   <= '0;
               stat_q  <= 1'b1;
               irq_q   <= 1'b1;
               icc_q   <= CC_OK;
               iparm_q <= pip_q;
            end else if (grant[Q_ST]) begin
               if (act_q[ACT_SUSP]) begin
                  act_q[ACT_RSP]  <= 1'b0;
                  act_q[ACT_SUSP] <= 1'b0;
                  act_q[ACT_RUN]  <= 1'b1;
                  start_q <= 1'b1;
                  lcv_q   <= 1'b1;
               end else begin
                  pip_q          <= orb_ip;
                  act_q[ACT_STP] <= 1'b0;
                  if (orb_path_ok) begin
                     act_q[ACT_RUN] <= 1'b1;
                     start_q <= 1'b1;
                     lcv_q   <= 1'b1;
                  end else begin
                     stat_q  <= 1'b1;
                     irq_q   <= 1'b1;
                     icc_q   <= CC_NOPATH;
                     iparm_q <= orb_ip;
                  end
               end
            end
         end

         // command effects
         if (acc) begin
            unique case (sfc_op_e'(cmd_op))
               OP_START: begin
                  fn_q           <= 3'b001;
                  act_q[ACT_STP] <= 1'b1;
                  cpa_q          <= cmd_cpa;
                  dst_q          <= '0;
                  cst_q          <= '0;
               end
               OP_HALT: begin
                  fn_q[FN_HT]    <= 1'b1;
                  act_q[ACT_HTP] <= 1'b1;
               end
               OP_CLEAR: begin
                  fn_q   <= 3'b100;
                  act_q  <= ACT_W'(1) << ACT_CLP;
                  stat_q <= 1'b0;
               end
               OP_RESUME: act_q[ACT_RSP] <= 1'b1;
               OP_CANCEL: begin
                  fn_q[FN_ST]     <= 1'b0;
                  act_q[ACT_STP]  <= 1'b0;
                  act_q[ACT_SUSP] <= 1'b0;
                  cpa_q <= '0;
                  lcv_q <= 1'b0;
                  dst_q <= '0;
                  cst_q <= '0;
               end
               OP_ACCEPT: begin
                  stat_q <= 1'b0;
                  fn_q   <= '0;
                  act_q  <= '0;
               end
               default: ;
            endcase
         end
      end
   end

   assign resp_valid     = rv_q;
   assign resp_cc        = rcc_q;
   assign fn_ctl         = fn_q;
   assign act_ctl        = act_q;
   assign stat_pend      = stat_q;
   assign dev_stat       = dst_q;
   assign chn_stat       = cst_q;
   assign last_cmd_valid = lcv_q;
   assign path_intparm   = pip_q;
   assign prog_start     = start_q;
   assign prog_addr      = cpa_q;
   assign irq            = irq_q;
   assign irq_cc         = icc_q;
   assign irq_parm       = iparm_q;

   // R12
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R3
   start_lcv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (last_cmd_valid && act_ctl[ACT_RUN] && !irq));
   // R1
   reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_cc != CC_OK) |-> (fn_ctl == $past(fn_ctl)));
   // R7
   stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_pend |-> !act_ctl[ACT_RUN]);
   // R4
   nopath_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && irq_cc == CC_NOPATH) |-> (stat_pend && !prog_start));
endmodule

// File: tb/subch_fc_seq_tb_top.sv
module subch_fc_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [31:0] cmd_intparm = '0;
   logic [7:0]  cmd_lpm = '0;
   logic [31:0] cmd_cpa = '0;
   logic        resp_valid;
   logic [1:0]  resp_cc;
   logic [2:0]  fn_ctl;
   logic [5:0]  act_ctl;
   logic        stat_pend;
   logic [7:0]  dev_stat, chn_stat;
   logic        last_cmd_valid;
   logic [31:0] path_intparm;
   logic        prog_start;
   logic [31:0] prog_addr;
   logic        prog_done = 1'b0;
   logic        prog_suspend = 1'b0;
   logic [7:0]  prog_dstat = '0;
   logic [7:0]  prog_cstat = '0;
   logic        irq;
   logic [1:0]  irq_cc;
   logic [31:0] irq_parm;

   int n_cmp = 0;
   int n_bad = 0;
   logic [1:0] got_cc;
   logic       got_rv;

   always #10 clk = ~clk;

   subch_fc_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_intparm(cmd_intparm), .cmd_lpm(cmd_lpm), .cmd_cpa(cmd_cpa),
      .resp_valid(resp_valid), .resp_cc(resp_cc), .fn_ctl(fn_ctl),
      .act_ctl(act_ctl), .stat_pend(stat_pend), .dev_stat(dev_stat),
      .chn_stat(chn_stat), .last_cmd_valid(last_cmd_valid),
      .path_intparm(path_intparm), .prog_start(prog_start),
      .prog_addr(prog_addr), .prog_done(prog_done),
      .prog_suspend(prog_suspend), .prog_dstat(prog_dstat),
      .prog_cstat(prog_cstat), .irq(irq), .irq_cc(irq_cc),
      .irq_parm(irq_parm)
   );

   localparam int NV = 13;
   localparam logic [2:0] V_OP [NV] = '{3'd6, 3'd4, 3'd5, 3'd2, 3'd1, 3'd6, 3'd1,
                                        3'd1, 3'd4, 3'd3, 3'd6, 3'd7, 3'd0};
   localparam logic [1:0] V_CC [NV] = '{2'd1, 2'd2, 2'd2, 2'd0, 2'd1, 2'd0, 2'd0,
                                        2'd2, 2'd2, 2'd0, 2'd0, 2'd3, 2'd3};
   localparam logic [2:0] V_FN [NV] = '{3'b000, 3'b000, 3'b000, 3'b010, 3'b010,
                                        3'b000, 3'b001, 3'b001, 3'b001, 3'b100,
                                        3'b000, 3'b000, 3'b000};
   localparam string V_REQ [NV] = '{"R1", "R1", "R1", "R5", "R1", "R10", "R2",
                                    "R1", "R1", "R6", "R10", "R1", "R1"};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [31:0] ip,
                        input logic [7:0] lpm, input logic [31:0] cpa);
      cmd_op = op; cmd_intparm = ip; cmd_lpm = lpm; cmd_cpa = cpa;
      cmd_valid = 1'b1;
      @(negedge clk);
      got_cc = resp_cc;
      got_rv = resp_valid;
      cmd_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      // R11 reset state
      @(negedge clk); @(negedge clk);
      chk("R11", {fn_ctl, act_ctl, stat_pend, last_cmd_valid}, '0);
      chk("R11", {irq, prog_start, resp_valid}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", prog_addr, '0);

      // table walk of command acceptance
      for (int i = 0; i < NV; i++) begin
         issue(V_OP[i], 32'h100 + i, 8'h80, 32'h1000 + i);
         chk(V_REQ[i], {got_rv, got_cc}, {1'b1, V_CC[i]});
         repeat (3) @(negedge clk);
         chk(V_REQ[i], fn_ctl, V_FN[i]);
      end

      // R2 / R3 / R7 normal start and completion
      issue(3'd1, 32'hA5A50001, 8'hC0, 32'h1234);
      chk("R2", got_cc, 2'd0);
      chk("R2", {fn_ctl, act_ctl}, {3'b001, 6'b000100});
      @(negedge clk);
      chk("R3", {prog_start, prog_addr}, {1'b1, 32'h1234});
      chk("R3", {path_intparm, last_cmd_valid, act_ctl}, {32'hA5A50001, 1'b1, 6'b000001});
      @(negedge clk);
      chk("R3", prog_start, 1'b0);
      prog_done = 1'b1; prog_dstat = 8'h0C;
      @(negedge clk);
      prog_done = 1'b0;
      chk("R7", {irq, irq_cc, irq_parm}, {1'b1, 2'd0, 32'hA5A50001});
      chk("R7", {stat_pend, dev_stat, act_ctl}, {1'b1, 8'h0C, 6'b0});
      @(negedge clk);
      chk("R12", irq, 1'b0);
      issue(3'd6, 0, 0, 0);
      chk("R10", {got_cc, stat_pend, fn_ctl, act_ctl}, '0);

      // R4 no usable path
      issue(3'd1, 32'h77, 8'h40, 32'h50);
      @(negedge clk);
      chk("R4", {irq, irq_cc, prog_start, irq_parm}, {1'b1, 2'd3, 1'b0, 32'h77});
      chk("R4", {stat_pend, path_intparm}, {1'b1, 32'h77});
      issue(3'd6, 0, 0, 0);

      // R5 halt beats start
      issue(3'd1, 32'h88, 8'h80, 32'h60);
      chk("R5", got_cc, 2'd0);
      issue(3'd2, 0, 0, 0);
      chk("R5", got_cc, 2'd0);
      @(negedge clk);
      chk("R5", {prog_start, irq, irq_cc}, {1'b0, 1'b1, 2'd0});
      chk("R5", {fn_ctl, act_ctl, prog_addr, last_cmd_valid}, {3'b011, 6'b0, 32'h0, 1'b0});
      @(negedge clk);
      chk("R5", prog_start, 1'b0);
      issue(3'd6, 0, 0, 0);

      // R6 clear while status pending
      issue(3'd2, 0, 0, 0);
      @(negedge clk);
      chk("R6", stat_pend, 1'b1);
      issue(3'd3, 0, 0, 0);
      chk("R6", {got_cc, stat_pend, fn_ctl, act_ctl}, {2'd0, 1'b0, 3'b100, 6'b100000});
      @(negedge clk);
      chk("R6", {irq, stat_pend}, 2'b11);
      issue(3'd6, 0, 0, 0);

      // R8 suspend and resume
      issue(3'd1, 32'h55, 8'h80, 32'h300);
      @(negedge clk);
      prog_suspend = 1'b1; prog_dstat = 8'h44; prog_cstat = 8'h02;
      @(negedge clk);
      prog_suspend = 1'b0;
      chk("R8", {act_ctl, irq, dev_stat}, {6'b000010, 1'b0, 8'h44});
      issue(3'd1, 32'h99, 8'h80, 32'h777);
      chk("R8", got_cc, 2'd2);
      issue(3'd4, 0, 0, 0);
      chk("R8", {got_cc, act_ctl}, {2'd0, 6'b001010});
      @(negedge clk);
      chk("R8", {prog_start, prog_addr, path_intparm}, {1'b1, 32'h300, 32'h55});
      chk("R8", act_ctl, 6'b000001);
      prog_done = 1'b1;
      @(negedge clk);
      prog_done = 1'b0;
      chk("R8", {irq, irq_parm}, {1'b1, 32'h55});
      issue(3'd6, 0, 0, 0);

      // R9 cancel after suspension
      issue(3'd1, 32'h66, 8'h80, 32'h400);
      @(negedge clk);
      prog_suspend = 1'b1; prog_dstat = 8'h44; prog_cstat = 8'h02;
      @(negedge clk);
      prog_suspend = 1'b0;
      issue(3'd5, 0, 0, 0);
      chk("R9", {got_cc, fn_ctl, act_ctl}, {2'd0, 3'b000, 6'b0});
      chk("R9", {prog_addr, dev_stat, chn_stat, last_cmd_valid}, '0);
      @(negedge clk);
      chk("R9", irq, 1'b0);

      // R11 reset in the middle of a program
      issue(3'd1, 32'h1, 8'h80, 32'h500);
      @(negedge clk);
      chk("R11", last_cmd_valid, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11", {last_cmd_valid, prog_addr, fn_ctl, act_ctl}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end
endmodule